// File: doc/BRIEF.md
# Bit-Sliced Signed Input Sequencer

This block feeds multi-bit signed activations into an analogue crossbar multiply array over several time slots. In each slot, every row gets one ternary digit: drive high, drive low, or leave undriven. Within a slot the block walks the column converter groups, one group per cycle. It adds each returned digitized column value into a full-precision signed partial sum for that column. Every slot's result is quantized by the converter on its own before it is added, and the block then combines these quantized results. It never quantizes the final product as a whole.

A mode bit, sampled at start, selects how an input is spread over slots. In bit-slice mode each two's-complement bit gets its own slot, and the block scales each result by its bit weight. In fully unrolled mode an input of magnitude m is applied as m unit-strength slots of its sign, and the results are added without scaling. The accumulators are cleared at start and saturate. A one-cycle done pulse marks the final add.

Top module: `bitslice_seq`

## Requirements
- R1: Row drive is ternary: row_pos[r]=1 applies +1, row_neg[r]=1 applies -1, and neither applies 0 (no drive). Both are never set together, and both are all-zero whenever busy is low.
- R2: mode=0 selects fully unrolled expansion and mode=1 selects bit-slice expansion. The value is captured when a start is accepted, and changes to it while busy have no effect.
- R3: Bit-slice mode runs IN_W slots. Slot k (k=0 first) drives +1 on each row whose input bit k is 1. The converted column value of slot k is shifted left by k. For k=IN_W-1 (the sign bit) that value is subtracted, and for every other k it is added.
- R4: Fully unrolled mode runs 2^(IN_W-1) slots. In slot t a row whose input x satisfies |x|>t is driven with the sign of x (+1 for positive, -1 for negative), and the converted values are added unshifted. An input of -2^(IN_W-1) is driven in every slot.
- R5: Each slot takes COLS/N_ADC cycles. grp_sel counts 0,1,... one step per cycle, and adc_data lane j (bits j*ADC_W upward, signed) belongs to column grp_sel*N_ADC+j. The row drive holds steady for the whole slot.
- R6: Each column sum is ACC_W-bit signed and is placed on acc_out at bits c*ACC_W upward. All sums read 0 in the cycle after a start is accepted. Each add saturates at the most positive and most negative values instead of wrapping.
- R7: done is high for exactly one cycle, and busy is low in that cycle. It rises SLOTS*(COLS/N_ADC) clock edges after the edge that accepted start, on the same edge that writes the final add.
- R8: A start while busy is ignored. After done, acc_out holds its values until the next accepted start.
- R9: The input vector (row r at bits r*IN_W upward, two's complement) is captured at the accepted start, and changes to act_in while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| mode | input | 1 | Expansion mode: 0 fully unrolled, 1 bit-slice |
| act_in | input | ROWS*IN_W | Signed input vector, one field per row |
| busy | output | 1 | Operation in progress; row drive valid |
| row_pos | output | ROWS | Per-row +1 drive for the current slot |
| row_neg | output | ROWS | Per-row -1 drive for the current slot |
| grp_sel | output | GRP_W | Converter group being collected this cycle |
| adc_data | input | N_ADC*ADC_W | Signed digitized column values for the selected group |
| acc_out | output | COLS*ACC_W | Saturating signed column partial sums |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench aims at the sign slot of bit-slice mode. A design that adds this slot instead of subtracting it returns a large positive sum for small negative inputs. The bench also checks that the most negative input is driven for all 2^(IN_W-1) unrolled slots, where a magnitude computed in IN_W bits would skip that row entirely. Large converter gains make single slots clip and push sums past the accumulator range. Here a wrapping adder flips the sign of the column, and a design that scaled a single final conversion would disagree with the per-slot model. A second start and changes to mode and act_in mid-run must leave both the result and the latency unchanged.

// File: rtl/bitslice_seq_pkg.sv
package bitslice_seq_pkg;

    typedef enum logic {
        EXP_UNROLL = 1'b0,
        EXP_SLICE  = 1'b1
    } exp_mode_e;

endpackage

// File: rtl/bss_row_drive.sv
module bss_row_drive
    import bitslice_seq_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int IN_W   = 8,
    parameter int SLOT_W = 8
) (
    input  logic [ROWS*IN_W-1:0] acts,
    input  exp_mode_e            mode,
    input  logic [SLOT_W-1:0]    slot,
    input  logic                 en,
    output logic [ROWS-1:0]      pos,
    output logic [ROWS-1:0]      neg
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [IN_W-1:0] x;
        logic [IN_W:0]   mag;
        logic [IN_W-1:0] shifted;
        logic            live;
        logic            p_d;
        logic            n_d;

        assign x = acts[r*IN_W +: IN_W];

        always_comb begin
            mag     = x[IN_W-1] ? ((IN_W+1)'(0) - {x[IN_W-1], x}) : {1'b0, x};
            shifted = x >> slot;
            live    = (mag > (IN_W+1)'(slot));
            if (mode == EXP_SLICE) begin
                p_d = en & shifted[0];
                n_d = 1'b0;
            end else begin
                p_d = en & live & ~x[IN_W-1];
                n_d = en & live &  x[IN_W-1];
            end
        end

        assign pos[r] = p_d;
        assign neg[r] = n_d;
    end

endmodule

// File: rtl/bss_acc_lane.sv
module bss_acc_lane #(
    parameter int ADC_W = 16,
    parameter int ACC_W = 20,
    parameter int SH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [ADC_W-1:0] sample,
    input  logic [SH_W-1:0]  shamt,
    input  logic             subtract,
    output logic [ACC_W-1:0] acc
);

    localparam int SUM_W = ACC_W + ADC_W + (1 << SH_W) + 1;
    localparam logic signed [SUM_W-1:0] SUM_TOP =
        {{(SUM_W-ACC_W+1){1'b0}}, {(ACC_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SUM_BOT =
        {{(SUM_W-ACC_W+1){1'b1}}, {(ACC_W-1){1'b0}}};

    logic [ACC_W-1:0]        acc_d, acc_q;
    logic signed [SUM_W-1:0] term;
    logic signed [SUM_W-1:0] base;
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        term = {{(SUM_W-ADC_W){sample[ADC_W-1]}}, sample};
        term = term <<< shamt;
        if (subtract) begin
            term = -term;
        end
        base  = {{(SUM_W-ACC_W){acc_q[ACC_W-1]}}, acc_q};
        sum   = base + term;
        acc_d = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (en) begin
            if (sum > SUM_TOP) begin
                acc_d = SUM_TOP[ACC_W-1:0];
            end else if (sum < SUM_BOT) begin
                acc_d = SUM_BOT[ACC_W-1:0];
            end else begin
                acc_d = sum[ACC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/bitslice_seq.sv
module bitslice_seq
    import bitslice_seq_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int IN_W  = 8,
    parameter int COLS  = 32,
    parameter int N_ADC = 8,
    parameter int ADC_W = 16,
    parameter int ACC_W = 20,
    localparam int NGRP  = COLS / N_ADC,
    localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   mode,
    input  logic [ROWS*IN_W-1:0]   act_in,
    output logic                   busy,
    output logic [ROWS-1:0]        row_pos,
    output logic [ROWS-1:0]        row_neg,
    output logic [GRP_W-1:0]       grp_sel,
    input  logic [N_ADC*ADC_W-1:0] adc_data,
    output logic [COLS*ACC_W-1:0]  acc_out,
    output logic                   done
);

    localparam int SLOT_W      = IN_W;
    localparam int SH_W        = (IN_W > 1) ? $clog2(IN_W) : 1;
    localparam int SLICE_LAST  = IN_W - 1;
    localparam int UNROLL_LAST = (1 << (IN_W - 1)) - 1;

    typedef struct packed {
        logic                 busy;
        logic                 done;
        exp_mode_e            mode;
        logic [SLOT_W-1:0]    slot;
        logic [GRP_W-1:0]     grp;
        logic [ROWS*IN_W-1:0] acts;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic              launch;
    logic              step;
    logic [SLOT_W-1:0] last_slot;
    logic [SH_W-1:0]   shamt;
    logic              subtract;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        launch     = start && !ctl_q.busy;
        step       = ctl_q.busy;
        last_slot  = (ctl_q.mode == EXP_SLICE) ? SLOT_W'(SLICE_LAST)
                                               : SLOT_W'(UNROLL_LAST);
        if (launch) begin
            ctl_d.busy = 1'b1;
            ctl_d.mode = exp_mode_e'(mode);
            ctl_d.slot = '0;
            ctl_d.grp  = '0;
            ctl_d.acts = act_in;
        end else if (step) begin
            if (ctl_q.grp == GRP_W'(NGRP - 1)) begin
                ctl_d.grp = '0;
                if (ctl_q.slot == last_slot) begin
                    ctl_d.busy = 1'b0;
                    ctl_d.done = 1'b1;
                    ctl_d.slot = '0;
                end else begin
                    ctl_d.slot = ctl_q.slot + 1'b1;
                end
            end else begin
                ctl_d.grp = ctl_q.grp + 1'b1;
            end
        end
        shamt    = (ctl_q.mode == EXP_SLICE) ? ctl_q.slot[SH_W-1:0] : '0;
        subtract = (ctl_q.mode == EXP_SLICE) && (ctl_q.slot == SLOT_W'(SLICE_LAST));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    bss_row_drive #(
        .ROWS   (ROWS),
        .IN_W   (IN_W),
        .SLOT_W (SLOT_W)
    ) u_drive (
        .acts (ctl_q.acts),
        .mode (ctl_q.mode),
        .slot (ctl_q.slot),
        .en   (ctl_q.busy),
        .pos  (row_pos),
        .neg  (row_neg)
    );

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int GI = c / N_ADC;
        localparam int LI = c % N_ADC;
        logic hit;

        assign hit = step && (ctl_q.grp == GRP_W'(GI));

        bss_acc_lane #(
            .ADC_W (ADC_W),
            .ACC_W (ACC_W),
            .SH_W  (SH_W)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (launch),
            .en       (hit),
            .sample   (adc_data[LI*ADC_W +: ADC_W]),
            .shamt    (shamt),
            .subtract (subtract),
            .acc      (acc_out[c*ACC_W +: ACC_W])
        );
    end

    assign busy    = ctl_q.busy;
    assign done    = ctl_q.done;
    assign grp_sel = ctl_q.grp;

endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
    parameter int ROWS  = 8,
    parameter int IN_W  = 8,
    parameter int COLS  = 32,
    parameter int N_ADC = 8,
    parameter int ADC_W = 16,
    parameter int ACC_W = 20,
    localparam int NGRP  = COLS / N_ADC,
    localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic [ROWS-1:0]       row_pos,
    input logic [ROWS-1:0]       row_neg,
    input logic [GRP_W-1:0]      grp_sel,
    input logic [COLS*ACC_W-1:0] acc_out,
    input logic                  done
);

    localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NGRP - 1);

    a_r1_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        (row_pos & row_neg) == '0);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (row_pos == '0 && row_neg == '0));

    a_r5_grp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && grp_sel != GRP_LAST) |=> (busy && grp_sel == GRP_W'($past(grp_sel) + 1'b1)));

    a_r5_rows_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && grp_sel != GRP_LAST) |=> ($stable(row_pos) && $stable(row_neg)));

    a_r6_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && acc_out == '0));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(acc_out));

endmodule

bind bitslice_seq bss_checker #(
    .ROWS  (ROWS),
    .IN_W  (IN_W),
    .COLS  (COLS),
    .N_ADC (N_ADC),
    .ADC_W (ADC_W),
    .ACC_W (ACC_W)
) u_bss_chk (.*);

// File: tb/test_bitslice_seq.sv
module test_bitslice_seq;

    localparam int ROWS    = 8;
    localparam int IN_W    = 8;
    localparam int COLS    = 32;
    localparam int N_ADC   = 8;
    localparam int ADC_W   = 16;
    localparam int ACC_W   = 20;
    localparam int NGRP    = COLS / N_ADC;
    localparam int GRP_W   = 2;
    localparam int ACC_MAX = 524287;
    localparam int ACC_MIN = -524288;
    localparam int ADC_MAX = 32767;
    localparam int ADC_MIN = -32768;
    localparam int LAT_SLICE  = IN_W * NGRP;
    localparam int LAT_UNROLL = (1 << (IN_W - 1)) * NGRP;

    // {mode, gain[15:0], acts[63:0]}
    localparam logic [80:0] VECS [6] = '{
        {1'b1, 16'd1,   64'h80FF7F01C33C0055},
        {1'b0, 16'd1,   64'h80FF7F01C33C0055},
        {1'b1, 16'd300, 64'h12F00FA55A817E33},
        {1'b0, 16'd300, 64'h12F00FA55A817E33},
        {1'b1, 16'd7,   64'h0000000000000000},
        {1'b0, 16'd5,   64'h08F804FC02FE01FF}
    };

    logic                   clk = 1'b0;
    logic                   rst_n;
    logic                   start;
    logic                   mode;
    logic [ROWS*IN_W-1:0]   act_in;
    logic                   busy;
    logic [ROWS-1:0]        row_pos;
    logic [ROWS-1:0]        row_neg;
    logic [GRP_W-1:0]       grp_sel;
    logic [N_ADC*ADC_W-1:0] adc_data;
    logic [COLS*ACC_W-1:0]  acc_out;
    logic                   done;

    int nchk = 0;
    int nfail = 0;
    int gain = 1;
    int expv [COLS];
    logic [ROWS-1:0] first_pos;
    logic [ROWS-1:0] first_neg;

    always #5 clk = ~clk;

    bitslice_seq #(
        .ROWS(ROWS), .IN_W(IN_W), .COLS(COLS),
        .N_ADC(N_ADC), .ADC_W(ADC_W), .ACC_W(ACC_W)
    ) i_bitslice_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .act_in(act_in),
        .busy(busy), .row_pos(row_pos), .row_neg(row_neg), .grp_sel(grp_sel),
        .adc_data(adc_data), .acc_out(acc_out), .done(done)
    );

    function automatic int wgt(int r, int c);
        if (c == 0) return 7;
        return ((r * 5 + c * 3) % 15) - 7;
    endfunction

    function automatic int clip(int v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // ideal crossbar dot product followed by a clipping converter
    always_comb begin
        for (int j = 0; j < N_ADC; j++) begin
            int col;
            int dot;
            col = int'(grp_sel) * N_ADC + j;
            dot = 0;
            for (int r = 0; r < ROWS; r++) begin
                if (row_pos[r]) dot = dot + wgt(r, col);
                else if (row_neg[r]) dot = dot - wgt(r, col);
            end
            adc_data[j*ADC_W +: ADC_W] = ADC_W'(clip(dot * gain, ADC_MIN, ADC_MAX));
        end
    end

    task automatic model(input logic m, input logic [63:0] a, input int g);
        int nsl;
        nsl = m ? IN_W : (1 << (IN_W - 1));
        for (int c = 0; c < COLS; c++) expv[c] = 0;
        for (int s = 0; s < nsl; s++) begin
            for (int c = 0; c < COLS; c++) begin
                int dot;
                int q;
                int term;
                dot = 0;
                for (int r = 0; r < ROWS; r++) begin
                    int x;
                    int d;
                    x = int'($signed(a[r*IN_W +: IN_W]));
                    d = 0;
                    if (m) d = int'(a[r*IN_W + s]);
                    else if (x > s) d = 1;
                    else if (-x > s) d = -1;
                    dot = dot + d * wgt(r, c);
                end
                q = clip(dot * g, ADC_MIN, ADC_MAX);
                if (m) term = (s == IN_W - 1) ? -(q * (1 << s)) : q * (1 << s);
                else term = q;
                expv[c] = clip(expv[c] + term, ACC_MIN, ACC_MAX);
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int col_val(int c);
        return int'($signed(acc_out[c*ACC_W +: ACC_W]));
    endfunction

    task automatic check_acc(input string req, input string what);
        int bad;
        int ba;
        int be;
        bad = -1; ba = 0; be = 0;
        for (int c = 0; c < COLS; c++) begin
            if (bad < 0 && col_val(c) != expv[c]) begin
                bad = c; ba = col_val(c); be = expv[c];
            end
        end
        check(bad < 0, req, what, ba, be);
    endtask

    task automatic run_op(input logic m, input logic [63:0] a, input int g, output int cyc);
        @(negedge clk);
        mode = m; act_in = a; gain = g; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        first_pos = row_pos;
        first_neg = row_neg;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        int cyc;
        logic [ROWS-1:0] ep;
        logic [ROWS-1:0] en;
        logic [COLS*ACC_W-1:0] snap;
        rst_n = 1'b0; start = 1'b0; mode = 1'b0; act_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R6 R7: reset state
        check(busy == 1'b0 && done == 1'b0, "R7", "reset busy/done", {busy, done}, 0);
        check(acc_out == '0, "R6", "reset acc_out zero", col_val(0), 0);
        check(row_pos == '0 && row_neg == '0, "R1", "reset rows undriven", {row_pos, row_neg}, 0);

        // table walk
        for (int v = 0; v < 6; v++) begin
            logic vm;
            int vg;
            logic [63:0] va;
            vm = VECS[v][80];
            vg = int'(VECS[v][79:64]);
            va = VECS[v][63:0];
            run_op(vm, va, vg, cyc);
            model(vm, va, vg);
            check_acc(vm ? "R3" : "R4", $sformatf("vector %0d column sums", v));
            check(cyc == (vm ? LAT_SLICE : LAT_UNROLL), "R7", $sformatf("vector %0d latency", v),
                  cyc, vm ? LAT_SLICE : LAT_UNROLL);
            for (int r = 0; r < ROWS; r++) begin
                int x;
                x = int'($signed(va[r*IN_W +: IN_W]));
                ep[r] = vm ? va[r*IN_W] : (x > 0);
                en[r] = vm ? 1'b0 : (x < 0);
            end
            check(first_pos == ep && first_neg == en, vm ? "R3" : "R4",
                  $sformatf("vector %0d slot-0 drive", v), {first_pos, first_neg}, {ep, en});
            @(negedge clk);
            check(done == 1'b0, "R7", "done lasts one cycle", done, 0);
        end

        // R6 saturation, bit-slice positive
        run_op(1'b1, {8{8'h7F}}, 2000, cyc);
        model(1'b1, {8{8'h7F}}, 2000);
        check(col_val(0) == ACC_MAX, "R6", "positive saturation column 0", col_val(0), ACC_MAX);
        check_acc("R6", "positive saturation all columns");
        // R6 saturation, bit-slice negative (sign slot only, R3)
        run_op(1'b1, {8{8'h80}}, 2000, cyc);
        check(col_val(0) == ACC_MIN, "R6", "negative saturation slice column 0", col_val(0), ACC_MIN);
        // R4 R6: most negative input driven in every unrolled slot
        run_op(1'b0, {8{8'h80}}, 2000, cyc);
        model(1'b0, {8{8'h80}}, 2000);
        check(col_val(0) == ACC_MIN, "R4", "unrolled -128 saturates column 0", col_val(0), ACC_MIN);
        check_acc("R4", "unrolled -128 all columns");
        // R4 small unrolled magnitudes with r6_ clear of previous sums
        run_op(1'b0, 64'h0100FF0002000000, 3, cyc);
        model(1'b0, 64'h0100FF0002000000, 3);
        check_acc("R6", "fresh clear then unrolled small inputs");

        // R8 R9 R2: second start and input changes while busy are ignored
        @(negedge clk);
        mode = 1'b1; act_in = 64'h3C81F00F7E0255AA; gain = 3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; mode = 1'b0; act_in = 64'h7F7F7F7F7F7F7F7F;
        @(negedge clk);
        start = 1'b0;
        cyc = 6;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        model(1'b1, 64'h3C81F00F7E0255AA, 3);
        check(cyc == LAT_SLICE, "R8", "restart ignored: latency", cyc, LAT_SLICE);
        check_acc("R9", "mid-run act_in and mode changes ignored");
        snap = acc_out;
        repeat (10) @(negedge clk);
        check(acc_out == snap && busy == 1'b0, "R8", "sums hold after done", col_val(1), int'($signed(snap[ACC_W +: ACC_W])));

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule